// File: doc/BRIEF.md
# Pattern-Based Address Sequencer

This block drives four address streams, one for each read port and one for each write port of two data RAMs. It does not store one control word per cycle. Each stream instead fetches compact instructions from its own single-port program ROM. Each instruction names an access pattern and expands into as many cycles of addresses as that pattern needs. There are four kinds of pattern: a linear run of consecutive addresses, a row-major matrix scan, a column-major (transposed) matrix scan, and a wait that emits nothing for a set number of cycles. Each instruction also carries a small operation-select field. That field is presented alongside each address, so the datapath control signals are spread across the four programs.

A program describes the work for one independent problem. When the instruction flagged as last has emitted its final address, the stream returns to instruction 0 and starts the next problem. Every address of problem p is shifted by p times a fixed region size, so each problem works in its own slice of the RAMs. A start pulse runs every stream through a configured number of problems. The block stays busy until all four streams are done.

Top module: `pattern_addr_seq`

## Requirements
- R1: After reset, `busy` is low, every bit of `addr_vld` is low, and every `prog_addr` field is 0.
- R2: Instruction word layout, from the least significant bit:
  - bits [1:0] kind: 0 linear, 1 row-major, 2 column-major, 3 wait.
  - bit [2] last-of-program flag.
  - bits [4:3] op.
  - bits [14:5] base.
  - bits [24:15] length.
  - bits [28:25] rows minus one.
  - bits [32:29] columns minus one.

  A `start` pulse while idle begins every stream at instruction 0 with problem 0. The first address appears in the cycle after `start`.
- R3: A linear instruction emits base, base+1, …, base+length (length+1 cycles) with `addr_vld` high and `op_sel` equal to its op field.
- R4: A row-major instruction on an R×C matrix emits base + r·C + c for every r<R and c<C, with c varying fastest (R·C cycles).
- R5: A column-major instruction emits the same set of addresses with r varying fastest, so consecutive addresses in one column differ by C.
- R6: A wait instruction holds `addr_vld` low for length+1 cycles and then continues with the next instruction.
- R7: A stream moves to the next instruction only after the current pattern has emitted its final cycle, and the next pattern's first address follows in the very next cycle.
- R8: After the final cycle of an instruction flagged last, the stream returns to instruction 0 for the next problem. In problem p every address is (pattern address + p·REGION) modulo 2^AW.
- R9: After NPROB problems a stream stops with `addr_vld` low. `busy` falls in the cycle after the last stream's final address and stays low.
- R10: A `start` pulse while `busy` is high is ignored. The address streams continue exactly as if it had not occurred.
- R11: The four streams run independently, each from its own program and `prog_addr` field, with differing instruction lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run of NPROB problems when idle |
| busy | output | 1 | High while any stream is emitting |
| prog_addr | output | NSTR·PCW | Per-stream instruction index to its program ROM |
| prog_word | input | NSTR·IW | Per-stream instruction word returned by the ROM in the same cycle |
| addr_out | output | NSTR·AW | Per-stream generated address |
| addr_vld | output | NSTR | Per-stream address valid |
| op_sel | output | NSTR·OPW | Per-stream operation select (0 when not valid) |

## Verification
The bench checks every cycle and every stream against an expected stream it builds itself. A miscounted inner or outer counter therefore shows as a wrong address or a wrong valid bit in the very cycle it goes astray. A program counter that advances early or late shifts every following address, which is caught at once. A wrong problem offset appears on the first address of the second problem. A stream that fails to stop keeps `busy` high past its expected end, which is flagged in the next cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    K_LIN  = 2'd0,
    K_ROW  = 2'd1,
    K_COL  = 2'd2,
    K_WAIT = 2'd3
  } kind_e;

  // Position of one element inside a pattern, before the problem offset.
  // For K_ROW: outer = row, inner = column.
  // For K_COL: outer = column, inner = row.
  function automatic logic [31:0] pat_offset(kind_e k, logic [31:0] base,
                                             logic [31:0] ncols,
                                             logic [31:0] inner,
                                             logic [31:0] outer);
    case (k)
      K_ROW:   return base + outer * ncols + inner;
      K_COL:   return base + inner * ncols + outer;
      default: return base + inner;
    endcase
  endfunction

  function automatic logic [31:0] region_base(logic [31:0] prob, logic [31:0] region);
    return prob * region;
  endfunction

endpackage

// File: rtl/seq_stream.sv
module seq_stream
  import seq_pkg::*;
#(
  parameter int AW     = 10,
  parameter int DW     = 4,
  parameter int OPW    = 2,
  parameter int PCW    = 3,
  parameter int NPROB  = 3,
  parameter int REGION = 64,
  parameter int IW     = 3 + OPW + 2 * AW + 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [IW-1:0]  word_i,
  output logic [PCW-1:0] pc_o,
  output logic [AW-1:0]  addr_o,
  output logic           vld_o,
  output logic [OPW-1:0] op_o,
  output logic           active_o
);
  localparam int F_OP   = 3;
  localparam int F_BASE = F_OP + OPW;
  localparam int F_LEN  = F_BASE + AW;
  localparam int F_ROWS = F_LEN + AW;
  localparam int F_COLS = F_ROWS + DW;
  localparam int CW     = (AW > DW) ? AW : DW;
  localparam int PBW    = (NPROB > 1) ? $clog2(NPROB) : 1;

  kind_e          kind;
  logic           last_f;
  logic [OPW-1:0] op_f;
  logic [AW-1:0]  base_f, len_f;
  logic [DW-1:0]  rows_f, cols_f;

  assign kind   = kind_e'(word_i[1:0]);
  assign last_f = word_i[2];
  assign op_f   = word_i[F_OP +: OPW];
  assign base_f = word_i[F_BASE +: AW];
  assign len_f  = word_i[F_LEN +: AW];
  assign rows_f = word_i[F_ROWS +: DW];
  assign cols_f = word_i[F_COLS +: DW];

  logic           active;
  logic [PCW-1:0] pc;
  logic [PBW-1:0] prob;
  logic [CW-1:0]  inner, outer;

  // Named events for assertions
  logic [CW-1:0] inner_max, outer_max;
  logic          pat_end, pass_end, sweep_end, prob_last;

  always_comb begin
    case (kind)
      K_ROW: begin
        inner_max = CW'(cols_f);
        outer_max = CW'(rows_f);
      end
      K_COL: begin
        inner_max = CW'(rows_f);
        outer_max = CW'(cols_f);
      end
      default: begin
        inner_max = CW'(len_f);
        outer_max = '0;
      end
    endcase
  end

  assign pat_end   = active && (inner == inner_max) && (outer == outer_max);
  assign pass_end  = pat_end && last_f;
  assign prob_last = (32'(prob) == NPROB - 1);
  assign sweep_end = pass_end && prob_last;

  logic [31:0] elem_pos, full_pos;
  assign elem_pos = pat_offset(kind, 32'(base_f), 32'(cols_f) + 32'd1,
                               32'(inner), 32'(outer));
  assign full_pos = elem_pos + region_base(32'(prob), 32'(REGION));

  assign addr_o   = full_pos[AW-1:0];
  assign vld_o    = active && (kind != K_WAIT);
  assign op_o     = vld_o ? op_f : '0;
  assign pc_o     = pc;
  assign active_o = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pc     <= '0;
      prob   <= '0;
      inner  <= '0;
      outer  <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        pc     <= '0;
        prob   <= '0;
        inner  <= '0;
        outer  <= '0;
      end
    end else if (pat_end) begin
      inner <= '0;
      outer <= '0;
      if (last_f) begin
        pc <= '0;
        if (prob_last) begin
          prob   <= '0;
          active <= 1'b0;
        end else begin
          prob <= prob + 1'b1;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end else if (inner == inner_max) begin
      inner <= '0;
      outer <= outer + 1'b1;
    end else begin
      inner <= inner + 1'b1;
    end
  end

  AST_PROB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (32'(prob) < NPROB)); // R8
  AST_INNER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (inner <= inner_max && outer <= outer_max)); // R7
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pat_end) |=> (pc == $past(pc))); // R7
  AST_NEXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !sweep_end) |=> (active && pc == '0 && prob != $past(prob))); // R8
  AST_SWEEP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end |=> !vld_o); // R9
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (kind == K_LIN || kind == K_ROW) && inner != '0)
      |-> (addr_o == AW'($past(addr_o) + AW'(1)))); // R3
  AST_COL_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind == K_COL && inner != '0)
      |-> (addr_o == AW'($past(addr_o) + AW'(cols_f) + AW'(1)))); // R5

endmodule

// File: rtl/pattern_addr_seq.sv
module pattern_addr_seq #(
  parameter int AW     = 10,
  parameter int DW     = 4,
  parameter int OPW    = 2,
  parameter int PCW    = 3,
  parameter int NPROB  = 3,
  parameter int REGION = 64,
  parameter int NSTR   = 4,
  localparam int IW    = 3 + OPW + 2 * AW + 2 * DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic [NSTR*PCW-1:0] prog_addr,
  input  logic [NSTR*IW-1:0]  prog_word,
  output logic [NSTR*AW-1:0]  addr_out,
  output logic [NSTR-1:0]     addr_vld,
  output logic [NSTR*OPW-1:0] op_sel
);
  logic [NSTR-1:0] str_active;
  logic            go;

  assign busy = |str_active;
  assign go   = start && !busy;

  for (genvar g = 0; g < NSTR; g++) begin : g_str
    seq_stream #(
      .AW(AW), .DW(DW), .OPW(OPW), .PCW(PCW),
      .NPROB(NPROB), .REGION(REGION), .IW(IW)
    ) u_stream (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .word_i   (prog_word[g*IW +: IW]),
      .pc_o     (prog_addr[g*PCW +: PCW]),
      .addr_o   (addr_out[g*AW +: AW]),
      .vld_o    (addr_vld[g]),
      .op_o     (op_sel[g*OPW +: OPW]),
      .active_o (str_active[g])
    );
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (addr_vld == '0)); // R9

endmodule

// File: tb/pattern_addr_seq_bench.sv
module pattern_addr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, DW = 4, OPW = 2, PCW = 3, NPROB = 3, REGION = 64, NSTR = 4;
  localparam int IW = 3 + OPW + 2 * AW + 2 * DW;
  localparam int NPC = 1 << PCW;
  localparam int QMAX = 256;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy;
  logic [NSTR*PCW-1:0] prog_addr;
  logic [NSTR*IW-1:0]  prog_word;
  logic [NSTR*AW-1:0]  addr_out;
  logic [NSTR-1:0]     addr_vld;
  logic [NSTR*OPW-1:0] op_sel;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pattern_addr_seq u_pattern_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .prog_addr(prog_addr), .prog_word(prog_word),
    .addr_out(addr_out), .addr_vld(addr_vld), .op_sel(op_sel)
  );

  // Program tables: kind, last, op, base, length, rows, cols (true counts)
  int p_kind [NSTR][NPC];
  int p_last [NSTR][NPC];
  int p_op   [NSTR][NPC];
  int p_base [NSTR][NPC];
  int p_len  [NSTR][NPC];
  int p_rows [NSTR][NPC];
  int p_cols [NSTR][NPC];

  function automatic logic [IW-1:0] enc(int k, int l, int o, int b, int n, int r, int c);
    logic [IW-1:0] w;
    w = '0;
    w[1:0]   = 2'(k);
    w[2]     = l[0];
    w[4:3]   = 2'(o);
    w[14:5]  = 10'(b);
    w[24:15] = 10'(n);
    w[28:25] = 4'(r - 1);
    w[32:29] = 4'(c - 1);
    return w;
  endfunction

  always_comb begin
    for (int s = 0; s < NSTR; s++) begin
      int pc;
      pc = int'(prog_addr[s*PCW +: PCW]);
      prog_word[s*IW +: IW] = enc(p_kind[s][pc], p_last[s][pc], p_op[s][pc],
                                  p_base[s][pc], p_len[s][pc], p_rows[s][pc], p_cols[s][pc]);
    end
  end

  // Expected streams
  int e_vld [NSTR][QMAX];
  int e_adr [NSTR][QMAX];
  int e_op  [NSTR][QMAX];
  int e_req [NSTR][QMAX];
  int e_n   [NSTR];
  int e_rd  [NSTR];

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  function automatic string tag(int code);
    case (code)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(bit ok, int code, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag(code), what, act, exp);
    end
  endtask

  task automatic push(int s, int v, int a, int o, int code);
    e_vld[s][e_n[s]] = v;
    e_adr[s][e_n[s]] = a % (1 << AW);
    e_op[s][e_n[s]]  = o;
    e_req[s][e_n[s]] = code;
    e_n[s]++;
  endtask

  task automatic set_ins(int s, int pc, int k, int l, int o, int b, int n, int r, int c);
    p_kind[s][pc] = k; p_last[s][pc] = l; p_op[s][pc] = o;
    p_base[s][pc] = b; p_len[s][pc] = n; p_rows[s][pc] = r; p_cols[s][pc] = c;
  endtask

  task automatic build(int r, int c, int ln);
    for (int s = 0; s < NSTR; s++)
      for (int pc = 0; pc < NPC; pc++) set_ins(s, pc, 0, 1, 0, 0, 0, 1, 1);
    set_ins(0, 0, 0, 0, 1, 5, ln, 1, 1);
    set_ins(0, 1, 1, 1, 2, 100, 0, r, c);
    set_ins(1, 0, 2, 0, 3, 200, 0, r, c);
    set_ins(1, 1, 0, 1, 1, 1020, 6, 1, 1);
    set_ins(2, 0, 3, 0, 0, 0, 2, 1, 1);
    set_ins(2, 1, 0, 0, 2, 40, 0, 1, 1);
    set_ins(2, 2, 1, 1, 3, 300, 0, c, r);
    set_ins(3, 0, 0, 1, 2, 0, r * c, 1, 1);
    for (int s = 0; s < NSTR; s++) begin
      e_n[s] = 0;
      e_rd[s] = 0;
      for (int p = 0; p < NPROB; p++) begin
        int off;
        off = p * REGION;
        for (int pc = 0; pc < NPC; pc++) begin
          int k, b, rr, cc, first;
          k = p_kind[s][pc]; b = p_base[s][pc];
          rr = p_rows[s][pc]; cc = p_cols[s][pc];
          first = e_n[s];
          if (k == 0) begin
            for (int i = 0; i <= p_len[s][pc]; i++) push(s, 1, off + b + i, p_op[s][pc], 3);
          end else if (k == 1) begin
            for (int i = 0; i < rr; i++)
              for (int j = 0; j < cc; j++) push(s, 1, off + b + i * cc + j, p_op[s][pc], 4);
          end else if (k == 2) begin
            for (int j = 0; j < cc; j++)
              for (int i = 0; i < rr; i++) push(s, 1, off + b + i * cc + j, p_op[s][pc], 5);
          end else begin
            for (int i = 0; i <= p_len[s][pc]; i++) push(s, 0, 0, 0, 6);
          end
          if (pc > 0) e_req[s][first] = 7;
          if (p > 0 && pc == 0) e_req[s][first] = 8;
          if (s == 1 && pc == 1 && p > 0) e_req[s][e_n[s] - 1] = 8;
          if (p_last[s][pc] != 0) break;
        end
      end
    end
  endtask

  task automatic run_case(int r, int c, int ln, int glitch_at);
    int cyc;
    build(r, c, ln);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk(busy === 1'b1, 2, "busy after start", int'(busy), 1);
    while (e_rd[0] < e_n[0] || e_rd[1] < e_n[1] || e_rd[2] < e_n[2] || e_rd[3] < e_n[3]) begin
      for (int s = 0; s < NSTR; s++) begin
        int code;
        if (e_rd[s] < e_n[s]) begin
          code = e_req[s][e_rd[s]];
          if (s == 3) code = (code == 3) ? 11 : code;
          chk(addr_vld[s] === e_vld[s][e_rd[s]][0], code, $sformatf("vld s%0d", s),
              int'(addr_vld[s]), e_vld[s][e_rd[s]]);
          if (e_vld[s][e_rd[s]] != 0) begin
            chk(int'(addr_out[s*AW +: AW]) == e_adr[s][e_rd[s]], code,
                $sformatf("addr s%0d", s), int'(addr_out[s*AW +: AW]), e_adr[s][e_rd[s]]);
            chk(int'(op_sel[s*OPW +: OPW]) == e_op[s][e_rd[s]], 3,
                $sformatf("op s%0d", s), int'(op_sel[s*OPW +: OPW]), e_op[s][e_rd[s]]);
          end
          e_rd[s]++;
        end else begin
          chk(addr_vld[s] === 1'b0, 9, $sformatf("stopped s%0d", s), int'(addr_vld[s]), 0);
        end
      end
      chk(busy === 1'b1, 9, "busy while emitting", int'(busy), 1);
      // R10: pulse start mid-run; expectations stay unchanged
      start = (cyc == glitch_at);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    for (int i = 0; i < 3; i++) begin
      chk(busy === 1'b0, 9, "busy after sweep", int'(busy), 0);
      chk(addr_vld === 4'b0, 9, "vld after sweep", int'(addr_vld), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int s = 0; s < NSTR; s++)
      for (int pc = 0; pc < NPC; pc++) set_ins(s, pc, 0, 1, 0, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, 1, "busy in reset", int'(busy), 0);
    chk(addr_vld === 4'b0, 1, "vld in reset", int'(addr_vld), 0);
    chk(prog_addr == '0, 1, "prog_addr in reset", int'(prog_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, 1, "idle after reset", int'(busy), 0);
    for (int r = 1; r <= 3; r++)
      for (int c = 1; c <= 3; c++)
        run_case(r, c, (r + c) % 4, r + 2 * c);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule